// File: doc/BRIEF.md
# Single-Accumulator Execution Core

This core runs a straight-line program held in an instruction memory. Every instruction names at most one data memory location. The core keeps one working register, the accumulator. Arithmetic instructions use it as their implied first operand and write their result back into it. The second operand is the data word at the address the instruction names. Only LOAD and STORE move values between the accumulator and memory.

The core fetches instruction words through a combinational instruction port, where the word appears in the same cycle as the address. It reaches data memory through a single-port interface with one cycle of read latency. A counter output shows how many data memory reads and writes the running program has made. Instruction fetches are not included in that count. The program ends with a HALT instruction. After HALT the core raises `done`, stops fetching and makes no further memory accesses.

Top module: `acc_core`

## Requirements
- R1: While synchronous reset (`rst` high) is asserted at a clock edge, the program counter, the accumulator and the reference counter go to 0 and `done` goes low. After reset the first fetch comes from instruction address 0.
- R2: An instruction word holds the opcode in bits [19:15] and a 15-bit data address in bits [14:0]. The opcodes are LOAD=1, STORE=2, ADD=3, SUB=4, MUL=5 and HALT=31.
- R3: LOAD places the addressed data word in the accumulator.
- R4: STORE writes the accumulator to the addressed data word and leaves the accumulator unchanged.
- R5: ADD replaces the accumulator with accumulator plus memory operand, modulo 2^16.
- R6: SUB replaces the accumulator with accumulator minus memory operand, modulo 2^16.
- R7: MUL replaces the accumulator with the low 16 bits of the product of the accumulator and the memory operand.
- R8: LOAD, STORE, ADD, SUB and MUL each make exactly one data memory access. Each access adds one to the 16-bit reference counter. Instruction fetches add nothing. Any other opcode except HALT makes no access and leaves the accumulator unchanged.
- R9: After HALT, `done` stays high. The instruction address and the reference counter then stay frozen, and no data memory access occurs.
- R10: The program counter advances by one after each instruction. STORE and no-access opcodes take 2 cycles. LOAD, ADD, SUB and MUL take 3 cycles. HALT reaches `done` 2 cycles after it is fetched.
- R11: A data read and a data write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 15 | Instruction address (program counter) |
| imem_data | input | 20 | Instruction word, valid in the same cycle as the address |
| dmem_addr | output | 15 | Data memory address |
| dmem_rd | output | 1 | Data read request; the data arrives on the next cycle |
| dmem_wr | output | 1 | Data write request |
| dmem_wdata | output | 16 | Data to be written |
| dmem_rdata | input | 16 | Read data, one cycle after `dmem_rd` |
| acc_out | output | 16 | Current accumulator value |
| ref_count | output | 16 | Number of data memory references made so far |
| done | output | 1 | High once HALT has executed |

## Verification
The bench runs one fixed program over all 64 operand pairs taken from a set of edge values: zero, one, the sign boundary, all ones and two mixed patterns. This sweep exposes several kinds of fault. ADD and SUB that do not wrap correctly give wrong results for these operands. A SUB with its operands swapped does too. So does a MUL that keeps the upper half of the product.

The program includes an unassigned opcode followed by a STORE. A core that touched memory or the accumulator on that opcode would show a reference count other than 10, or a wrong stored value.

The bench also checks timing and the halted state. It counts the cycles to `done`, which catches sequencing that adds or drops a state. After halt it watches for several cycles, which catches a core that keeps fetching or keeps counting once stopped.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OPC_LOAD  = 5'd1,
      OPC_STORE = 5'd2,
      OPC_ADD   = 5'd3,
      OPC_SUB   = 5'd4,
      OPC_MUL   = 5'd5,
      OPC_HALT  = 5'd31
   } opcode_t;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_WB    = 2'd2,
      ST_HALT  = 2'd3
   } seq_state_t;

   function automatic logic reads_memory(input logic [OP_W-1:0] op);
      return (op == OPC_LOAD) || (op == OPC_ADD) ||
             (op == OPC_SUB)  || (op == OPC_MUL);
   endfunction

endpackage

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
   import acc_core_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [OP_W+ADDR_W-1:0] instr,
   output logic [ADDR_W-1:0]      pc,
   output logic [OP_W-1:0]        op,
   output logic [ADDR_W-1:0]      opnd_addr,
   output logic                   mem_rd,
   output logic                   mem_wr,
   output logic                   acc_we,
   output logic                   halted
);

   localparam int INSTR_W = OP_W + ADDR_W;

   seq_state_t              state;
   logic [INSTR_W-1:0]      ir;
   logic [ADDR_W-1:0]       pc_next;

   assign op        = ir[INSTR_W-1 -: OP_W];
   assign opnd_addr = ir[ADDR_W-1:0];
   assign pc_next   = pc + ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= '0;
         ir    <= '0;
      end else begin
         unique case (state)
            ST_FETCH: begin
               ir    <= instr;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (op == OPC_HALT) begin
                  state <= ST_HALT;
               end else if (reads_memory(op)) begin
                  state <= ST_WB;
               end else begin
                  pc    <= pc_next;
                  state <= ST_FETCH;
               end
            end
            ST_WB: begin
               pc    <= pc_next;
               state <= ST_FETCH;
            end
            ST_HALT: state <= ST_HALT;
            default: state <= ST_FETCH;
         endcase
      end
   end

   always_comb begin
      mem_rd = (state == ST_EXEC) && reads_memory(op);
      mem_wr = (state == ST_EXEC) && (op == OPC_STORE);
      acc_we = (state == ST_WB);
      halted = (state == ST_HALT);
   end

   // R11: read and write never share a cycle
   a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R9: halted state holds and the program counter freezes
   a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc)));

   // R9: no memory traffic once halted
   a_r9_quiet_when_halted: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_rd && !mem_wr));

   // R10: completion of a read-type instruction steps the program counter
   a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
      acc_we |=> (pc == ADDR_W'($past(pc) + 1'b1)));

endmodule

// File: rtl/acc_core_dpath.sv
module acc_core_dpath
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   op,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] acc
);

   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] product;
   logic [DATA_W-1:0] result;

   assign product = PROD_W'(acc) * PROD_W'(opnd);

   always_comb begin
      unique case (op)
         OPC_LOAD: result = opnd;
         OPC_ADD:  result = acc + opnd;
         OPC_SUB:  result = acc - opnd;
         OPC_MUL:  result = product[DATA_W-1:0];
         default:  result = acc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (acc_we) acc <= result;
   end

   // R4, R8: the accumulator moves only on a write-back cycle
   a_r4_acc_held: assert property (@(posedge clk) disable iff (rst)
      !acc_we |=> $stable(acc));

endmodule

// File: rtl/acc_core_refcnt.sv
module acc_core_refcnt #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst)                         count <= '0;
            else if (hit && count != CNT_MAX) count <= count + CNT_W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)      count <= '0;
            else if (hit) count <= count + CNT_W'(1);
         end

         // R8: each reference adds exactly one
         a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
            hit |=> (count == CNT_W'($past(count) + 1'b1)));
      end
   endgenerate

   // R8: no reference, no change
   a_r8_count_idle: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(count));

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 16,
   parameter bit CNT_SAT   = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst,
   output logic [ADDR_W-1:0]      imem_addr,
   input  logic [OP_W+ADDR_W-1:0] imem_data,
   output logic [ADDR_W-1:0]      dmem_addr,
   output logic                   dmem_rd,
   output logic                   dmem_wr,
   output logic [DATA_W-1:0]      dmem_wdata,
   input  logic [DATA_W-1:0]      dmem_rdata,
   output logic [DATA_W-1:0]      acc_out,
   output logic [CNT_W-1:0]       ref_count,
   output logic                   done
);

   generate
      if (ADDR_W < 1 || DATA_W < 2 || CNT_W < 1) begin : g_bad_cfg
         $error("acc_core: widths out of range");
      end
   endgenerate

   logic [OP_W-1:0] op;
   logic            acc_we;

   acc_core_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .instr     (imem_data),
      .pc        (imem_addr),
      .op        (op),
      .opnd_addr (dmem_addr),
      .mem_rd    (dmem_rd),
      .mem_wr    (dmem_wr),
      .acc_we    (acc_we),
      .halted    (done)
   );

   acc_core_dpath #(.DATA_W(DATA_W)) u_dpath (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .acc_we (acc_we),
      .opnd   (dmem_rdata),
      .acc    (acc_out)
   );

   acc_core_refcnt #(.CNT_W(CNT_W), .SATURATE(CNT_SAT)) u_refcnt (
      .clk   (clk),
      .rst   (rst),
      .hit   (dmem_rd | dmem_wr),
      .count (ref_count)
   );

   assign dmem_wdata = acc_out;

   // R4: a store never disturbs the accumulator in the following cycle
   a_r4_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
      dmem_wr |=> $stable(acc_out));

   // R9: counter frozen after halt
   a_r9_count_frozen: assert property (@(posedge clk) disable iff (rst)
      done |=> $stable(ref_count));

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [14:0] imem_addr;
   logic [19:0] imem_data;
   logic [14:0] dmem_addr;
   logic        dmem_rd, dmem_wr;
   logic [15:0] dmem_wdata;
   logic [15:0] dmem_rdata = '0;
   logic [15:0] acc_out, ref_count;
   logic        done;

   logic [19:0] imem [64];
   logic [15:0] dmem [64];

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int seen_refs = 0;
   int both_req = 0;

   always #5 clk = ~clk;

   acc_core uut (
      .clk(clk), .rst(rst),
      .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .acc_out(acc_out), .ref_count(ref_count), .done(done)
   );

   assign imem_data = imem[imem_addr[5:0]];

   always @(posedge clk) begin
      if (dmem_wr) dmem[dmem_addr[5:0]] <= dmem_wdata;
      if (dmem_rd) dmem_rdata <= dmem[dmem_addr[5:0]];
   end

   always @(negedge clk) begin
      cycles++;
      if (!rst) begin
         if (dmem_rd || dmem_wr) seen_refs++;
         if (dmem_rd && dmem_wr) both_req++;
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // R2 encodings, written independently of the design
   localparam logic [4:0] K_LOAD = 5'd1, K_STORE = 5'd2, K_ADD = 5'd3,
                          K_SUB = 5'd4, K_MUL = 5'd5, K_NOP = 5'd0,
                          K_HALT = 5'd31;

   function automatic logic [19:0] ins(input logic [4:0] opc, input int adr);
      return {opc, 15'(adr)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_pair(input logic [15:0] a, input logic [15:0] b, input bit full);
      int edges;
      logic [14:0] halt_pc;
      logic [15:0] cnt_at_halt;
      logic [15:0] e_add, e_sub, e_mul;
      logic [31:0] prod;
      e_add = a + b;
      e_sub = a - b;
      prod  = 32'(a) * 32'(b);
      e_mul = prod[15:0];

      for (int i = 0; i < 64; i++) begin imem[i] = ins(K_HALT, 0); dmem[i] = 16'h5A5A; end
      dmem[0] = a; dmem[1] = b;
      imem[0]  = ins(K_LOAD, 0);
      imem[1]  = ins(K_ADD, 1);
      imem[2]  = ins(K_STORE, 10);
      imem[3]  = ins(K_LOAD, 0);
      imem[4]  = ins(K_SUB, 1);
      imem[5]  = ins(K_STORE, 11);
      imem[6]  = ins(K_LOAD, 0);
      imem[7]  = ins(K_MUL, 1);
      imem[8]  = ins(K_STORE, 12);
      imem[9]  = ins(K_NOP, 1);
      imem[10] = ins(K_STORE, 13);
      imem[11] = ins(K_HALT, 0);

      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      if (full) begin
         check("R1 pc", 32'(imem_addr), 0);
         check("R1 acc", 32'(acc_out), 0);
         check("R1 count", 32'(ref_count), 0);
         check("R1 done", 32'(done), 0);
      end
      seen_refs = 0;
      both_req  = 0;
      rst = 1'b0;
      edges = 0;
      while (!done && edges < 200) begin
         @(negedge clk);
         edges++;
      end
      check("R9 done reached", 32'(done), 1);
      // R10: 3 loads + 3 ALU ops at 3 cycles, 4 stores + 1 no-op at 2, halt 2
      check("R10 cycles to done", 32'(edges), 30);
      check("R10 halt pc", 32'(imem_addr), 11);
      check("R5 add", 32'(dmem[10]), 32'(e_add));
      check("R6 sub", 32'(dmem[11]), 32'(e_sub));
      check("R7 mul", 32'(dmem[12]), 32'(e_mul));
      check("R8 nop keeps acc / R4 store", 32'(dmem[13]), 32'(e_mul));
      check("R3 acc after program", 32'(acc_out), 32'(e_mul));
      check("R8 ref count", 32'(ref_count), 10);
      check("R8 refs seen on port", 32'(seen_refs), 10);
      check("R4 operand untouched", 32'(dmem[0]), 32'(a));
      halt_pc = imem_addr;
      cnt_at_halt = ref_count;
      for (int k = 0; k < 5; k++) @(negedge clk);
      check("R9 done held", 32'(done), 1);
      check("R9 pc frozen", 32'(imem_addr), 32'(halt_pc));
      check("R9 count frozen", 32'(ref_count), 32'(cnt_at_halt));
      check("R9 no access after halt", 32'(seen_refs), 10);
      check("R11 no read+write", 32'(both_req), 0);
   endtask

   initial begin
      logic [15:0] vals [8];
      vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
      vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'hABCD;
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++)
            run_pair(vals[i], vals[j], (i == 0 && j == 0) || (i == 7 && j == 5));
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule